// File: doc/BRIEF.md
# Multiplexed-address DRAM controller

This block connects a simple synchronous request port to a one-bit-wide DRAM whose address arrives in two halves over a shared set of pins. For every host request it places the row half on the pins and strobes the row line, then presents the column half and strobes the column line. Before the row line is released, it runs a restore phase that writes the row back into the cells, because opening a row empties it. Each phase lasts a parameterised number of clock cycles.

After an access the row stays open. A later request to the same row needs only a new column phase. A request to a different row first restores and closes the open row, inserts one precharge cycle with the row strobe high, and then opens the new row. A background scheduler raises a refresh request at a fixed interval. Each refresh opens and restores the next row in ascending order, so the whole array is visited within the retention window. The host never has to ask for this. Any accepted access is finished before a refresh is serviced.

Top module: `dram_mux_ctrl`

## Requirements
- R1: The row number is the upper ADDR_W/2 request address bits. It is driven on `dram_addr` while `dram_ras_n` falls. The column number is the lower ADDR_W/2 bits. It is driven while `dram_cas_n` is low. A read returns the bit last written to that address.
- R2: A read accepted while no row is open (`dram_ras_n` high) returns `rd_valid` exactly T_ROW+T_COL clock edges after the accepting edge.
- R3: After an access, `dram_ras_n` stays low. A read to the open row returns `rd_valid` T_COL edges after acceptance.
- R4: A request to a row other than the open one returns its read data T_WB+1+T_ROW+T_COL edges after acceptance. That count covers the restore phase, a one-cycle precharge with `dram_ras_n` high, and a new row phase.
- R5: Every period with `dram_ras_n` low ends with at least T_WB cycles in which `dram_cas_n` is high before `dram_ras_n` rises. Stored data therefore survives any number of row openings.
- R6: For a write, `dram_we_n` is low (0 = write) and `dram_din` carries the write bit for the whole time `dram_cas_n` is low. Those values stay stable while the strobe is low. `dram_cas_n` is never low while `dram_ras_n` is high.
- R7: Without any host action, every row receives a refresh cycle at least once every REFRESH_WINDOW clock cycles. A refresh cycle opens the row with no column strobe and then restores it.
- R8: Refreshes visit rows in ascending order, and the row after NUM_ROWS-1 is 0.
- R9: `req_ready` is high only when the controller is idle or holding a row open and no refresh is pending. It is low during the row, column, restore and precharge phases and during refresh.
- R10: After reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `rd_valid` is low and `req_ready` is high.
- R11: `rd_valid` is a one-cycle pulse per read. A write produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at a clock edge when valid and ready are both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Bit address; row in upper half, column in lower half |
| req_wdata | input | 1 | Write bit |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 1 | Read bit, valid while rd_valid is high |
| dram_addr | output | ADDR_W/2 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_din | output | 1 | Data to the DRAM |
| dram_dout | input | 1 | Data from the DRAM, sampled on the last column cycle |

## Verification
Read latency is fixed by the controller's state at acceptance. It is T_ROW+T_COL edges from idle, T_COL edges on a hit to the open row, and T_WB+1+T_ROW+T_COL edges on a row change. The bench reads `req_ready` and `dram_ras_n` on the falling edge before the accepting rising edge to tell which case applies. It then counts falling edges until `rd_valid`, so it expects the pulse at the falling edge numbered latency+1, and checks that the pulse is gone one falling edge later. A DRAM model in the bench samples the strobes on falling edges and empties a row when it opens. It puts the row back only if the restore window was long enough, which lets the data readback expose a skipped restore. The same model records when each row was last restored and the order of refresh-only cycles, and the bench compares these with the retention window and the ascending row sequence.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ROW     = 3'd1,
        ST_COL     = 3'd2,
        ST_OPEN    = 3'd3,
        ST_WB      = 3'd4,
        ST_PRE     = 3'd5,
        ST_REF_ROW = 3'd6,
        ST_REF_WB  = 3'd7
    } dmc_state_e;

endpackage

// File: rtl/dmc_phase_timer.sv
module dmc_phase_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         done_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = value_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/dmc_refresh_sched.sv
module dmc_refresh_sched #(
    parameter int ROWS     = 256,
    parameter int INTERVAL = 179
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    done_i,
    output logic                    pending_o,
    output logic [$clog2(ROWS)-1:0] row_o
);

    localparam int RW = $clog2(ROWS);
    localparam int TW = $clog2(INTERVAL + 1);

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic          pend;
        logic [RW-1:0] row;
    } sched_s;

    sched_s s_d, s_q;
    logic   tick;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.tmr == TW'(INTERVAL - 1));
        s_d.tmr = tick ? '0 : s_q.tmr + 1'b1;
        if (done_i) begin
            s_d.pend = 1'b0;
            s_d.row  = (s_q.row == RW'(ROWS - 1)) ? '0 : s_q.row + 1'b1;
        end
        if (tick) s_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pending_o = s_q.pend;
    assign row_o     = s_q.row;

endmodule

// File: rtl/dmc_addr_mux.sv
module dmc_addr_mux
    import dmc_pkg::*;
#(
    parameter int W = 8
) (
    input  dmc_state_e   state_i,
    input  logic [W-1:0] req_row_i,
    input  logic [W-1:0] req_col_i,
    input  logic [W-1:0] open_row_i,
    input  logic [W-1:0] ref_row_i,
    output logic [W-1:0] addr_o
);

    always_comb begin
        case (state_i)
            ST_ROW:                addr_o = req_row_i;
            ST_COL:                addr_o = req_col_i;
            ST_WB, ST_OPEN:        addr_o = open_row_i;
            ST_REF_ROW, ST_REF_WB: addr_o = ref_row_i;
            default:               addr_o = '0;
        endcase
    end

endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int T_ROW          = 3,
    parameter int T_COL          = 1,
    parameter int T_WB           = 2,
    parameter int REFRESH_WINDOW = 50000,
    parameter int REF_SLACK      = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_wdata,
    output logic                rd_valid,
    output logic                rd_data,
    output logic [ADDR_W/2-1:0] dram_addr,
    output logic                dram_ras_n,
    output logic                dram_cas_n,
    output logic                dram_we_n,
    output logic                dram_din,
    input  logic                dram_dout
);

    localparam int HALF_W       = ADDR_W / 2;
    localparam int NUM_ROWS     = 1 << HALF_W;
    localparam int REF_INTERVAL = REFRESH_WINDOW / NUM_ROWS - REF_SLACK;
    localparam int TMR_W        = $clog2(T_ROW + T_COL + T_WB + 1);

    typedef struct packed {
        dmc_state_e        st;
        logic [HALF_W-1:0] open_row;
        logic [HALF_W-1:0] row;
        logic [HALF_W-1:0] col;
        logic              wr;
        logic              wd;
        logic              miss_pend;
        logic              rd_valid;
        logic              rd_data;
    } ctrl_s;

    ctrl_s             c_d, c_q;
    logic              accept;
    logic              phase_done;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              ref_pending;
    logic              ref_done;
    logic [HALF_W-1:0] ref_row;
    logic [HALF_W-1:0] in_row;
    logic [HALF_W-1:0] in_col;

    dmc_phase_timer #(.W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tmr_load),
        .value_i (tmr_val),
        .done_o  (phase_done)
    );

    dmc_refresh_sched #(.ROWS(NUM_ROWS), .INTERVAL(REF_INTERVAL)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (ref_done),
        .pending_o (ref_pending),
        .row_o     (ref_row)
    );

    dmc_addr_mux #(.W(HALF_W)) u_mux (
        .state_i    (c_q.st),
        .req_row_i  (c_q.row),
        .req_col_i  (c_q.col),
        .open_row_i (c_q.open_row),
        .ref_row_i  (ref_row),
        .addr_o     (dram_addr)
    );

    assign in_row    = req_addr[ADDR_W-1:HALF_W];
    assign in_col    = req_addr[HALF_W-1:0];
    assign req_ready = ((c_q.st == ST_IDLE) || (c_q.st == ST_OPEN)) && !ref_pending;
    assign accept    = req_valid && req_ready;

    always_comb begin
        c_d          = c_q;
        c_d.rd_valid = 1'b0;
        tmr_load     = 1'b0;
        tmr_val      = '0;
        ref_done     = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (ref_pending) begin
                    c_d.st   = ST_REF_ROW;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_ROW - 1);
                end else if (accept) begin
                    c_d.st       = ST_ROW;
                    c_d.row      = in_row;
                    c_d.col      = in_col;
                    c_d.wr       = req_write;
                    c_d.wd       = req_wdata;
                    c_d.open_row = in_row;
                    tmr_load     = 1'b1;
                    tmr_val      = TMR_W'(T_ROW - 1);
                end
            end
            ST_ROW: begin
                if (phase_done) begin
                    c_d.st   = ST_COL;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_COL - 1);
                end
            end
            ST_COL: begin
                if (phase_done) begin
                    c_d.st = ST_OPEN;
                    if (!c_q.wr) begin
                        c_d.rd_valid = 1'b1;
                        c_d.rd_data  = dram_dout;
                    end
                end
            end
            ST_OPEN: begin
                if (ref_pending) begin
                    c_d.st        = ST_WB;
                    c_d.miss_pend = 1'b0;
                    tmr_load      = 1'b1;
                    tmr_val       = TMR_W'(T_WB - 1);
                end else if (accept) begin
                    c_d.row = in_row;
                    c_d.col = in_col;
                    c_d.wr  = req_write;
                    c_d.wd  = req_wdata;
                    if (in_row == c_q.open_row) begin
                        c_d.st   = ST_COL;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(T_COL - 1);
                    end else begin
                        c_d.st        = ST_WB;
                        c_d.miss_pend = 1'b1;
                        tmr_load      = 1'b1;
                        tmr_val       = TMR_W'(T_WB - 1);
                    end
                end
            end
            ST_WB: begin
                if (phase_done) c_d.st = ST_PRE;
            end
            ST_PRE: begin
                if (c_q.miss_pend) begin
                    c_d.st        = ST_ROW;
                    c_d.miss_pend = 1'b0;
                    c_d.open_row  = c_q.row;
                    tmr_load      = 1'b1;
                    tmr_val       = TMR_W'(T_ROW - 1);
                end else if (ref_pending) begin
                    c_d.st   = ST_REF_ROW;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_ROW - 1);
                end else begin
                    c_d.st = ST_IDLE;
                end
            end
            ST_REF_ROW: begin
                if (phase_done) begin
                    c_d.st   = ST_REF_WB;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_WB - 1);
                end
            end
            ST_REF_WB: begin
                if (phase_done) begin
                    c_d.st   = ST_PRE;
                    ref_done = 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign dram_ras_n = (c_q.st == ST_IDLE) || (c_q.st == ST_PRE);
    assign dram_cas_n = (c_q.st != ST_COL);
    assign dram_we_n  = !((c_q.st == ST_COL) && c_q.wr);
    assign dram_din   = (c_q.st == ST_COL) ? c_q.wd : 1'b0;
    assign rd_valid   = c_q.rd_valid;
    assign rd_data    = c_q.rd_data;

endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int T_WB = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic din,
    input logic ready,
    input logic rd_valid
);

    logic [7:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 run_q <= '0;
        else if (!ras_n && cas_n)   run_q <= (run_q == 8'hFF) ? run_q : run_q + 1'b1;
        else                        run_q <= '0;
    end

    assert_restore_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (run_q >= 8'(T_WB)));

    assert_cas_inside_ras_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    assert_write_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && $past(!cas_n)) |-> ($stable(we_n) && $stable(din)));

    assert_busy_in_column_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ready);

    assert_busy_in_precharge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> !ready);

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_row_held_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !ras_n);

endmodule

bind dram_mux_ctrl dmc_checker #(.T_WB(T_WB)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (dram_ras_n),
    .cas_n    (dram_cas_n),
    .we_n     (dram_we_n),
    .din      (dram_din),
    .ready    (req_ready),
    .rd_valid (rd_valid)
);

// File: tb/dram_mux_ctrl_test.sv
module dram_mux_ctrl_test;

    localparam int AW     = 8;
    localparam int HW     = AW / 2;
    localparam int NR     = 1 << HW;
    localparam int NB     = 1 << AW;
    localparam int TR     = 3;
    localparam int TC     = 2;
    localparam int TW     = 2;
    localparam int WINDOW = 640;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_wdata = 1'b0;
    logic          req_ready, rd_valid, rd_data;
    logic [HW-1:0] dram_addr;
    logic          dram_ras_n, dram_cas_n, dram_we_n, dram_din, dram_dout;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dram_mux_ctrl #(
        .ADDR_W(AW), .T_ROW(TR), .T_COL(TC), .T_WB(TW),
        .REFRESH_WINDOW(WINDOW), .REF_SLACK(8)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_din(dram_din), .dram_dout(dram_dout)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- DRAM model (sampled on falling edges) ----------------
    logic cells  [NB];
    logic rowbuf [NR];
    int   last_visit [NR];
    logic prev_ras = 1'b1;
    int   m_row = 0, oc = 0, wbrun = 0, cyc = 0, max_age = 0;
    bit   cas_seen = 1'b0;
    int   exp_ref = 0, ref_count = 0;

    assign dram_dout = (!dram_cas_n) ? rowbuf[dram_addr] : 1'b0;

    initial begin
        for (int i = 0; i < NB; i++) cells[i] = 1'b0;
        for (int i = 0; i < NR; i++) begin rowbuf[i] = 1'b0; last_visit[i] = 0; end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!dram_ras_n && prev_ras) begin
                m_row = int'(dram_addr);
                for (int c = 0; c < NR; c++) begin
                    rowbuf[c] = cells[m_row*NR + c];
                    cells[m_row*NR + c] = ~rowbuf[c];
                end
                oc = 0; wbrun = 0; cas_seen = 1'b0;
            end else if (!dram_ras_n) begin
                oc++;
                if (!dram_cas_n) begin
                    cas_seen = 1'b1;
                    wbrun = 0;
                    if (!dram_we_n) rowbuf[dram_addr] = dram_din;
                end else if (oc >= TR) begin
                    wbrun++;
                end
            end else if (!prev_ras) begin
                check(wbrun >= TW, "R5 restore window", wbrun, TW);
                if (wbrun >= TW) begin
                    for (int c = 0; c < NR; c++) cells[m_row*NR + c] = rowbuf[c];
                    last_visit[m_row] = cyc;
                end
                if (!cas_seen) begin
                    check(m_row == exp_ref, "R8 refresh order", m_row, exp_ref);
                    exp_ref = (exp_ref + 1) % NR;
                    ref_count++;
                end
            end
            for (int r = 0; r < NR; r++)
                if (cyc - last_visit[r] > max_age) max_age = cyc - last_visit[r];
            prev_ras = dram_ras_n;
        end
    end

    // ---------------- host side ----------------
    logic refm [NB];
    int   open_row_tb = -1;

    function automatic logic pat(input int a);
        return ((a ^ (a >> 3) ^ (a >> 5)) & 1) != 0;
    endfunction

    task automatic do_req(input logic wr, input int a, input logic wd);
        int  exp_lat, n, row;
        bit  was_open, bad;
        string tag;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = wd;
        while (!req_ready) @(negedge clk);
        was_open = !dram_ras_n;
        row = a >> HW;
        if (!was_open)              begin exp_lat = TR + TC;          tag = "R2 idle latency"; end
        else if (row == open_row_tb) begin exp_lat = TC;              tag = "R3 hit latency";  end
        else                        begin exp_lat = TW + 1 + TR + TC; tag = "R4 miss latency"; end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        open_row_tb = row;
        n = 1;
        if (!wr) begin
            while (!rd_valid && n < 100) begin @(negedge clk); n++; end
            check(n == exp_lat + 1, tag, n - 1, exp_lat);
            check(rd_data == refm[a], "R1 read data", int'(rd_data), int'(refm[a]));
            @(negedge clk);
            check(!rd_valid, "R11 pulse width", int'(rd_valid), 0);
        end else begin
            refm[a] = wd;
            bad = 1'b0;
            for (int k = 0; k < exp_lat + 2; k++) begin
                if (rd_valid) bad = 1'b1;
                @(negedge clk);
            end
            check(!bad, "R11 no response to write", int'(bad), 0);
        end
    endtask

    task automatic run_all();
        logic [15:0] lfsr;
        int a;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dram_ras_n && dram_cas_n && dram_we_n, "R10 strobes idle", 
              int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
        check(!rd_valid, "R10 rd_valid low", int'(rd_valid), 0);
        check(req_ready, "R10 ready high", int'(req_ready), 1);
        // R6: write every bit, row-major order
        for (int i = 0; i < NB; i++) do_req(1'b1, i, pat(i));
        // R1/R3: read back row-major (page hits)
        for (int i = 0; i < NB; i++) do_req(1'b0, i, 1'b0);
        // R4: read back column-major (row change on every access)
        for (int c = 0; c < NR; c++)
            for (int r = 0; r < NR; r++) do_req(1'b0, r*NR + c, 1'b0);
        // mixed traffic with an LFSR
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = int'(lfsr[AW-1:0]);
            do_req(lfsr[9], a, lfsr[11]);
        end
        // R7: refresh alone keeps the data
        repeat (2 * WINDOW) @(negedge clk);
        for (int i = 0; i < NB; i += 7) do_req(1'b0, i, 1'b0);
        check(max_age <= WINDOW, "R7 retention age", max_age, WINDOW);
        check(ref_count >= 2 * NR, "R7 refresh count", ref_count, 2 * NR);
        check(exp_ref != 0 || ref_count % NR == 0, "R8 wrap", exp_ref, ref_count % NR);
    endtask

    initial begin
        for (int i = 0; i < NB; i++) refm[i] = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule